// File: doc/BRIEF.md
# Memory Poison List Manager

This block keeps a bounded record of the cache lines of a memory device that hold data known to be bad. An uncorrectable error can be reported to it from three places: a host read that hit the error, a host write that carried already-poisoned data, or a detection made by the device itself. Each report is reduced to a 64-byte line address. A line that is not yet recorded is stored, and a one-cycle notification pulse tells the host that the list has grown.

The host works the list through a command/response port. It can read the whole list out, one entry per response. It can remove one line it has dealt with. When reports have been lost because the list was full, it can start a media scan. A sticky overflow flag records that loss. The scan empties the list, then walks every line of the media at a slow pace, probing each one through a probe/answer pair of pins, and records the bad lines it finds. The scan ends with a completion pulse and a response. If the list fills while the scan still has bad lines to report, the scan stops early and the overflow flag stays set.

Top module: `poison_list_mgr`

## Requirements
- R1: After reset the list is empty (`entryCount` 0), `overflow`, `notify`, `scanDone` and `rspValid` are 0, and `cmdReady` is 1.
- R2: An error report (`errValid` with `errSrc` 0 = host read, 1 = poisoned host write, 2 = device detection) records line `errAddr >> 6` in the lowest-numbered free slot, and `entryCount` rises by one in the cycle after the report. The low six address bits are ignored. `errSrc` 3 is reserved and the report is ignored.
- R3: A report that adds a new line raises `notify` for exactly the one cycle after the report cycle.
- R4: A report whose line is already recorded adds nothing and raises no `notify`.
- R5: A report of a new line while all DEPTH slots are full is dropped without `notify`, and it sets `overflow`. `overflow` then stays set through clears and further reports, and drops only when a scan completes.
- R6: Command op 1 (list) returns every recorded line in slot order, one response per cycle, with `rspStatus` 0 (ok), `rspAddr` = line << 6, and `rspLast` on the final one. An empty list gives a single response with status 2 (empty) and `rspLast` set.
- R7: Command op 2 (clear) with a recorded line removes it, lowers `entryCount` and responds with status 0. A line not in the list leaves the list unchanged and responds with status 1 (invalid address). Either response carries the line-aligned address and `rspLast`.
- R8: Command op 3 (scan) empties the list and probes lines 0 to MEDIA_LINES-1 in ascending order, recording each line answered bad. After the last probe it gives one response with status 0, pulses `scanDone` in the same cycle, and clears `overflow`.
- R9: If a scan finds a bad line that is not yet recorded while the list is full, it stops at once. It gives a response with status 3 (halted) and a `scanDone` pulse, `overflow` stays set, and the list holds the first DEPTH bad lines found.
- R10: `cmdReady` is 0 from the acceptance of a list or scan command until its final response. Scan probes are at least SCAN_GAP cycles apart and never occur in two consecutive cycles.
- R11: Lines recorded by a scan raise no `notify`. Only the completion pulse `scanDone` is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | 1 list, 2 clear, 3 scan, 0 ignored |
| cmdAddr | input | ADDR_W | Byte address for clear |
| cmdReady | output | 1 | Command accepted when high together with cmdValid |
| rspValid | output | 1 | Response present (one cycle) |
| rspStatus | output | 2 | 0 ok, 1 invalid address, 2 empty, 3 halted |
| rspAddr | output | ADDR_W | Line-aligned address of the entry |
| rspLast | output | 1 | Final response of the command |
| errValid | input | 1 | Uncorrectable error report |
| errSrc | input | 2 | Report origin; 3 reserved |
| errAddr | input | ADDR_W | Byte address of the error |
| probeValid | output | 1 | Scan probes a line this cycle |
| probeLine | output | ADDR_W-6 | Line index being probed |
| probeBad | input | 1 | Same-cycle answer: the probed line is bad |
| notify | output | 1 | New entry added by a report |
| scanDone | output | 1 | Scan finished (complete or halted) |
| overflow | output | 1 | Sticky: a report was lost to a full list |
| entryCount | output | clog2(DEPTH+1) | Number of recorded lines |

## Verification
The bench builds the block with DEPTH = 8, MEDIA_LINES = 64, SCAN_GAP = 3 and a 20-bit address. The small depth lets a few reports fill the list, so overflow, its persistence across clears, and the early scan halt all occur within a short run. The short media lets a full scan finish in about two hundred cycles. Two bad-line patterns on the probe answer are used: one sparse enough for a scan to complete, and one dense enough to halt it on the ninth bad line.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LIST  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_SCAN  = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_BAD_ADDR = 2'd1,
    ST_EMPTY    = 2'd2,
    ST_HALTED   = 2'd3
  } rspStat_e;

  // strobes from control into the entry store
  typedef struct packed {
    logic insEn;
    logic clrEn;
    logic wipe;
  } storeCtl_t;

  // lookup results from the entry store back to control
  typedef struct packed {
    logic insDup;
    logic insRoom;
    logic clrHit;
  } storeFb_t;

endpackage

// File: rtl/poison_store.sv
module poison_store
  import poison_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LINE_W = 40,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCtl_t         ctl,
  input  logic [LINE_W-1:0] insLine,
  input  logic [LINE_W-1:0] clrLine,
  input  logic [IDX_W-1:0]  rdIdx,
  output storeFb_t          fb,
  output logic [DEPTH-1:0]  validVec,
  output logic [LINE_W-1:0] rdLine,
  output logic [CNT_W-1:0]  count
);

  logic [LINE_W-1:0] lineMem [DEPTH];
  logic [DEPTH-1:0]  validQ;
  logic [CNT_W-1:0]  countQ;
  logic [DEPTH-1:0]  insMatch;
  logic [DEPTH-1:0]  clrMatch;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  clrIdx;
  logic              roomAvail;
  logic              doAdd;
  logic              doDrop;

  // one comparator pair per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign insMatch[g] = validQ[g] && (lineMem[g] == insLine);
    assign clrMatch[g] = validQ[g] && (lineMem[g] == clrLine);
  end

  always_comb begin
    roomAvail = 1'b0;
    freeIdx   = '0;
    clrIdx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        roomAvail = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (clrMatch[i]) clrIdx = IDX_W'(i);
    end
  end

  assign fb.insDup  = |insMatch;
  assign fb.insRoom = roomAvail;
  assign fb.clrHit  = |clrMatch;

  assign doAdd  = ctl.insEn && !fb.insDup && roomAvail && !ctl.wipe;
  assign doDrop = ctl.clrEn && fb.clrHit && !ctl.wipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      countQ <= '0;
    end else if (ctl.wipe) begin
      validQ <= '0;
      countQ <= '0;
    end else begin
      if (doDrop) validQ[clrIdx] <= 1'b0;
      if (doAdd)  validQ[freeIdx] <= 1'b1;
      countQ <= countQ + CNT_W'(doAdd) - CNT_W'(doDrop);
    end
  end

  always_ff @(posedge clk) begin
    if (doAdd) lineMem[freeIdx] <= insLine;
  end

  assign validVec = validQ;
  assign rdLine   = lineMem[rdIdx];
  assign count    = countQ;

  // R5: the entry count never exceeds the slot count
  p_count_bound_r5 : assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));

  // R4: a duplicate insert alone leaves the count unchanged
  p_dup_no_growth_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.insEn && fb.insDup && !ctl.clrEn && !ctl.wipe) |=> $stable(countQ));

  // R2: the count follows the occupied slots
  p_count_tracks_r2 : assert property (@(posedge clk) disable iff (!rstN)
    32'(countQ) == $countones(validQ));

endmodule

// File: rtl/poison_ctrl.sv
module poison_ctrl
  import poison_pkg::*;
#(
  parameter int ADDR_W      = 46,
  parameter int LINE_OFF    = 6,
  parameter int DEPTH       = 32,
  parameter int MEDIA_LINES = 4096,
  parameter int SCAN_GAP    = 16,
  localparam int LINE_W = ADDR_W - LINE_OFF,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SCAN_W = $clog2(MEDIA_LINES),
  localparam int GAP_W  = (SCAN_GAP > 1) ? $clog2(SCAN_GAP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspLast,
  input  logic              errValid,
  input  logic [1:0]        errSrc,
  input  logic [ADDR_W-1:0] errAddr,
  output logic              probeValid,
  output logic [LINE_W-1:0] probeLine,
  input  logic              probeBad,
  output logic              notify,
  output logic              scanDone,
  output logic              overflow,
  output storeCtl_t         storeCtl,
  output logic [LINE_W-1:0] insLine,
  output logic [LINE_W-1:0] clrLine,
  output logic [IDX_W-1:0]  rdIdx,
  input  storeFb_t          fb,
  input  logic [DEPTH-1:0]  validVec,
  input  logic [LINE_W-1:0] rdLine,
  input  logic [CNT_W-1:0]  count
);

  typedef enum logic [1:0] {S_IDLE, S_LIST, S_SCAN} phase_e;

  phase_e            phase;
  logic [SCAN_W-1:0] scanIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic              cmdFire;
  logic              errOk;
  logic              gapHit;
  logic              scanBlocked;
  logic              scanLast;
  logic              moreAfter;
  logic              unusedLowBits;

  assign unusedLowBits = ^{cmdAddr[LINE_OFF-1:0], errAddr[LINE_OFF-1:0]};

  assign cmdReady = (phase == S_IDLE);
  assign cmdFire  = cmdValid && cmdReady;
  assign errOk    = errValid && (errSrc != 2'd3);
  assign gapHit   = (gapCnt == GAP_W'(SCAN_GAP - 1));

  // host reports take the insert port; a due probe waits one cycle
  assign probeValid = (phase == S_SCAN) && gapHit && !errOk;
  assign probeLine  = LINE_W'(scanIdx);

  assign clrLine = cmdAddr[ADDR_W-1:LINE_OFF];
  assign insLine = errOk ? errAddr[ADDR_W-1:LINE_OFF] : probeLine;

  assign storeCtl.insEn = errOk || (probeValid && probeBad);
  assign storeCtl.clrEn = cmdFire && (cmdOp == OP_CLEAR);
  assign storeCtl.wipe  = cmdFire && (cmdOp == OP_SCAN);

  assign scanBlocked = probeValid && probeBad && !fb.insDup && !fb.insRoom;
  assign scanLast    = probeValid && (scanIdx == SCAN_W'(MEDIA_LINES - 1));

  always_comb begin
    moreAfter = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i > int'(rdIdx) && validVec[i]) moreAfter = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= S_IDLE;
      rdIdx     <= '0;
      scanIdx   <= '0;
      gapCnt    <= '0;
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      rspAddr   <= '0;
      rspLast   <= 1'b0;
      notify    <= 1'b0;
      scanDone  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspLast  <= 1'b0;
      scanDone <= 1'b0;
      notify   <= errOk && !fb.insDup && fb.insRoom && !storeCtl.wipe;
      if (storeCtl.insEn && !fb.insDup && !fb.insRoom && !storeCtl.wipe)
        overflow <= 1'b1;

      unique case (phase)
        S_IDLE: begin
          if (cmdFire) begin
            unique case (cmdOp)
              OP_LIST: begin
                if (count == '0) begin
                  rspValid  <= 1'b1;
                  rspStatus <= ST_EMPTY;
                  rspAddr   <= '0;
                  rspLast   <= 1'b1;
                end else begin
                  phase <= S_LIST;
                  rdIdx <= '0;
                end
              end
              OP_CLEAR: begin
                rspValid  <= 1'b1;
                rspStatus <= fb.clrHit ? ST_OK : ST_BAD_ADDR;
                rspAddr   <= {clrLine, {LINE_OFF{1'b0}}};
                rspLast   <= 1'b1;
              end
              OP_SCAN: begin
                phase   <= S_SCAN;
                scanIdx <= '0;
                gapCnt  <= '0;
              end
              default: ;
            endcase
          end
        end
        S_LIST: begin
          rdIdx <= rdIdx + IDX_W'(1);
          if (validVec[rdIdx]) begin
            rspValid  <= 1'b1;
            rspStatus <= ST_OK;
            rspAddr   <= {rdLine, {LINE_OFF{1'b0}}};
            rspLast   <= !moreAfter;
            if (!moreAfter) phase <= S_IDLE;
          end else if (rdIdx == IDX_W'(DEPTH - 1)) begin
            phase <= S_IDLE;
          end
        end
        S_SCAN: begin
          if (probeValid) begin
            gapCnt <= '0;
            if (scanBlocked) begin
              rspValid  <= 1'b1;
              rspStatus <= ST_HALTED;
              rspAddr   <= '0;
              rspLast   <= 1'b1;
              scanDone  <= 1'b1;
              phase     <= S_IDLE;
            end else if (scanLast) begin
              rspValid  <= 1'b1;
              rspStatus <= ST_OK;
              rspAddr   <= '0;
              rspLast   <= 1'b1;
              scanDone  <= 1'b1;
              overflow  <= 1'b0;
              phase     <= S_IDLE;
            end else begin
              scanIdx <= scanIdx + SCAN_W'(1);
            end
          end else if (!gapHit) begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  // R3: a notification follows a host report
  p_notify_cause_r3 : assert property (@(posedge clk) disable iff (!rstN)
    notify |-> $past(errValid));

  // R5: overflow only drops when a scan finishes
  p_overflow_sticky_r5 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> scanDone);

  // R9: a halted scan leaves overflow set
  p_halt_keeps_ovf_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == ST_HALTED) |-> overflow);

  // R10: probes are never back to back
  p_probe_spacing_r10 : assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> !probeValid);

  // R8: scan completion always comes with a final response
  p_done_has_rsp_r8 : assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (rspValid && rspLast));

endmodule

// File: rtl/poison_list_mgr.sv
module poison_list_mgr
  import poison_pkg::*;
#(
  parameter int ADDR_W      = 46,
  parameter int LINE_BYTES  = 64,
  parameter int DEPTH       = 32,
  parameter int MEDIA_LINES = 4096,
  parameter int SCAN_GAP    = 16,
  localparam int LINE_OFF = $clog2(LINE_BYTES),
  localparam int LINE_W   = ADDR_W - LINE_OFF,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspLast,
  input  logic              errValid,
  input  logic [1:0]        errSrc,
  input  logic [ADDR_W-1:0] errAddr,
  output logic              probeValid,
  output logic [LINE_W-1:0] probeLine,
  input  logic              probeBad,
  output logic              notify,
  output logic              scanDone,
  output logic              overflow,
  output logic [CNT_W-1:0]  entryCount
);

  storeCtl_t         storeCtl;
  storeFb_t          storeFb;
  logic [LINE_W-1:0] insLine;
  logic [LINE_W-1:0] clrLine;
  logic [IDX_W-1:0]  rdIdx;
  logic [DEPTH-1:0]  validVec;
  logic [LINE_W-1:0] rdLine;

  poison_ctrl #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .DEPTH(DEPTH),
    .MEDIA_LINES(MEDIA_LINES), .SCAN_GAP(SCAN_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdReady(cmdReady),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspAddr(rspAddr), .rspLast(rspLast),
    .errValid(errValid), .errSrc(errSrc), .errAddr(errAddr),
    .probeValid(probeValid), .probeLine(probeLine), .probeBad(probeBad),
    .notify(notify), .scanDone(scanDone), .overflow(overflow),
    .storeCtl(storeCtl), .insLine(insLine), .clrLine(clrLine), .rdIdx(rdIdx),
    .fb(storeFb), .validVec(validVec), .rdLine(rdLine), .count(entryCount)
  );

  poison_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rstN(rstN), .ctl(storeCtl), .insLine(insLine), .clrLine(clrLine),
    .rdIdx(rdIdx), .fb(storeFb), .validVec(validVec), .rdLine(rdLine),
    .count(entryCount)
  );

endmodule

// File: tb/poison_list_mgr_bench.sv
module poison_list_mgr_bench;

  localparam int ADDR_W = 20;
  localparam int DEPTH  = 8;
  localparam int MEDIA  = 64;
  localparam int GAP    = 3;
  localparam int LW     = ADDR_W - 6;
  localparam int CW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [1:0]        cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic              cmdReady;
  logic              rspValid;
  logic [1:0]        rspStatus;
  logic [ADDR_W-1:0] rspAddr;
  logic              rspLast;
  logic              errValid = 1'b0;
  logic [1:0]        errSrc = '0;
  logic [ADDR_W-1:0] errAddr = '0;
  logic              probeValid;
  logic [LW-1:0]     probeLine;
  logic              probeBad;
  logic              notify;
  logic              scanDone;
  logic              overflow;
  logic [CW-1:0]     entryCount;

  int checks = 0;
  int fails  = 0;
  int badMode = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  poison_list_mgr #(
    .ADDR_W(ADDR_W), .LINE_BYTES(64), .DEPTH(DEPTH),
    .MEDIA_LINES(MEDIA), .SCAN_GAP(GAP)
  ) u_poison_list_mgr (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdReady(cmdReady), .rspValid(rspValid), .rspStatus(rspStatus),
    .rspAddr(rspAddr), .rspLast(rspLast), .errValid(errValid), .errSrc(errSrc),
    .errAddr(errAddr), .probeValid(probeValid), .probeLine(probeLine),
    .probeBad(probeBad), .notify(notify), .scanDone(scanDone),
    .overflow(overflow), .entryCount(entryCount)
  );

  // media model: which lines answer bad to a probe
  function automatic bit isBad(int mode, logic [LW-1:0] l);
    if (mode == 0) return (l % 16) == 5;
    return (l % 4) == 1;
  endfunction

  assign probeBad = probeValid && isBad(badMode, probeLine);

  // reference list
  logic [LW-1:0] mLine [DEPTH];
  bit            mValid [DEPTH];
  bit            mOvf = 1'b0;
  int            mCount = 0;

  typedef struct {
    logic [1:0]        st;
    logic [ADDR_W-1:0] addr;
    logic              last;
    string             req;
  } exp_t;
  exp_t expQ[$];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare every response against the scoreboard
  always @(negedge clk) begin : mon
    exp_t e;
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R6: actual unexpected response st=%0d addr=%h expected none",
                 rspStatus, rspAddr);
      end else begin
        e = expQ.pop_front();
        if (rspStatus !== e.st || rspAddr !== e.addr || rspLast !== e.last) begin
          fails++;
          $display("FAIL %s: actual st=%0d addr=%h last=%0d expected st=%0d addr=%h last=%0d",
                   e.req, rspStatus, rspAddr, rspLast, e.st, e.addr, e.last);
        end
      end
    end
  end

  function automatic void pushExp(logic [1:0] st, logic [ADDR_W-1:0] a, logic last, string req);
    exp_t e;
    e.st = st; e.addr = a; e.last = last; e.req = req;
    expQ.push_back(e);
  endfunction

  task automatic drain(string req);
    int guard = 0;
    while ((expQ.size() != 0 || !cmdReady) && guard < 500) begin
      @(posedge clk); #2;
      guard++;
    end
    if (guard >= 500) check(req, expQ.size(), 0);
  endtask

  task automatic sendCmd(logic [1:0] op, logic [ADDR_W-1:0] a);
    @(posedge clk); #2;
    while (!cmdReady) begin @(posedge clk); #2; end
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a;
    @(posedge clk); #2;
    cmdValid = 1'b0;
  endtask

  // error report; checks R2/R3/R4/R5 behaviour at the ports
  task automatic report(int src, logic [ADDR_W-1:0] a, string req);
    logic [LW-1:0] line = a[ADDR_W-1:6];
    bit dup = 1'b0;
    bit added = 1'b0;
    if (src != 3) begin
      for (int i = 0; i < DEPTH; i++) if (mValid[i] && mLine[i] == line) dup = 1'b1;
      if (!dup) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!added && !mValid[i]) begin
            mValid[i] = 1'b1; mLine[i] = line; added = 1'b1; mCount++;
          end
        end
        if (!added) mOvf = 1'b1;
      end
    end
    @(posedge clk); #2;
    errValid = 1'b1; errSrc = 2'(src); errAddr = a;
    @(posedge clk);
    @(negedge clk);
    errValid = 1'b0;
    check({req, " notify"}, int'(notify), int'(added));
    check({req, " count"}, int'(entryCount), mCount);
    check({req, " overflow"}, int'(overflow), int'(mOvf));
  endtask

  // R6: full read-out in slot order
  task automatic listCheck(string req);
    int last = -1;
    for (int i = 0; i < DEPTH; i++) if (mValid[i]) last = i;
    if (last < 0) pushExp(2'd2, '0, 1'b1, req);
    else
      for (int i = 0; i <= last; i++)
        if (mValid[i]) pushExp(2'd0, {mLine[i], 6'b0}, (i == last), req);
    sendCmd(2'd1, '0);
    drain(req);
  endtask

  // R7: clear by address
  task automatic clearCheck(logic [ADDR_W-1:0] a, string req);
    logic [LW-1:0] line = a[ADDR_W-1:6];
    bit hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (mValid[i] && mLine[i] == line) begin
        mValid[i] = 1'b0; hit = 1'b1; mCount--;
      end
    pushExp(hit ? 2'd0 : 2'd1, {line, 6'b0}, 1'b1, req);
    sendCmd(2'd2, a);
    check({req, " count"}, int'(entryCount), mCount);
    drain(req);
  endtask

  // R8/R9/R10/R11: scan with a chosen media pattern
  task automatic scanCheck(int mode, string req);
    bit halt = 1'b0;
    int notes = 0;
    int guard = 0;
    for (int i = 0; i < DEPTH; i++) mValid[i] = 1'b0;
    mCount = 0;
    for (int l = 0; l < MEDIA; l++) begin
      if (!halt && isBad(mode, LW'(l))) begin
        if (mCount < DEPTH) begin
          mValid[mCount] = 1'b1; mLine[mCount] = LW'(l); mCount++;
        end else halt = 1'b1;
      end
    end
    mOvf = halt ? 1'b1 : 1'b0;
    badMode = mode;
    pushExp(halt ? 2'd3 : 2'd0, '0, 1'b1, req);
    sendCmd(2'd3, '0);
    check("R10 busy during scan", int'(cmdReady), 0);
    do begin
      @(negedge clk);
      if (notify) notes++;
      guard++;
    end while (!scanDone && guard < 2000);
    check({req, " scanDone seen"}, int'(scanDone), 1);
    check("R11 no per-entry notify in scan", notes, 0);
    drain(req);
    check({req, " overflow"}, int'(overflow), int'(mOvf));
    check({req, " count"}, int'(entryCount), mCount);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < DEPTH; i++) begin mValid[i] = 1'b0; mLine[i] = '0; end
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", int'(entryCount), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 notify", int'(notify), 0);
    check("R1 ready", int'(cmdReady), 1);
    check("R1 rspValid", int'(rspValid), 0);

    listCheck("R6 empty list");

    report(0, 20'h00043, "R2 host read");
    report(1, 20'h00140, "R2 poisoned write");
    report(2, 20'h0027F, "R3 device detect");
    report(1, 20'h00171, "R4 duplicate line");
    report(3, 20'h00800, "R2 reserved source ignored");
    listCheck("R6 three entries");

    clearCheck(20'h00155, "R7 clear hit");
    clearCheck(20'h01340, "R7 clear miss");
    listCheck("R7 list after clear");

    report(0, 20'h00500, "R2 lowest free slot");
    listCheck("R2 slot order after refill");

    for (int k = 0; k < 5; k++) report(2, ADDR_W'((30 + k) * 64), "R3 fill");
    report(0, 20'h00A00, "R5 overflow on full");
    report(0, 20'h00A40, "R5 second drop");
    listCheck("R6 full list");
    clearCheck(20'h00780, "R5 clear keeps overflow");
    check("R5 sticky overflow", int'(overflow), 1);

    scanCheck(0, "R8 scan complete");
    listCheck("R8 list after scan");

    for (int k = 0; k < 4; k++) report(1, ADDR_W'((100 + k) * 64), "R3 refill");
    report(2, 20'h01A00, "R5 overflow again");
    scanCheck(1, "R9 scan halted");
    listCheck("R9 list after halt");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule